// File: doc/BRIEF.md
# Capture/Compare Value Register with Preload and Shadow Stages

This block keeps one 16-bit capture/compare value in two stages. A preload stage faces the bus, and a shadow stage faces the timer hardware. The bus only sees the preload stage, through separate high-byte and low-byte read and write strobes. The hardware only uses the shadow stage.

In input mode, a capture event latches the free-running counter into the shadow stage. On the next cycle that value moves up into the preload stage, where software can read it. In output mode, values written by software move down from the preload stage into the shadow stage. The move happens at once, or only on an update event when preload buffering is enabled. A registered comparator then checks the shadow value against the counter.

A 16-bit access is split into two byte accesses, so two lock flags keep each pair of bytes coherent. A high-byte read opens a read lock, and a capture cannot overwrite the preload stage until the low byte has been read. A high-byte write opens a write lock, and the shadow stage cannot take a half-written value until the low byte has been written. A sticky overcapture flag reports a capture that lands while an earlier captured value is still unread.

Top module: `cmpcap_reg`

## Requirements
- R1: While reset is high and after it is released, the preload stage, the shadow stage, the read data, the match output and both capture flags are zero.
- R2: The high-byte strobes access bits 15:8 and the low-byte strobes access bits 7:0 of the preload stage. Read data is registered: it appears the cycle after the read strobe and holds until the next read strobe.
- R3: A mode select of 2'b00 is output mode, and any nonzero value is input mode. In input mode, bus writes leave the preload stage unchanged.
- R4: In output mode with preload buffering off, the shadow stage takes the preload value on the clock edge that follows the preload change, unless the write lock is open.
- R5: The write lock opens on a high-byte write and closes on a low-byte write. While it is open, the shadow stage does not change.
- R6: In output mode with preload buffering on, the shadow stage loads only on an update event. An update event that arrives while the write lock is open is held, and it is applied on the edge after the lock closes.
- R7: In input mode, a pulse on the capture input or on the software capture input loads the counter into the shadow stage on that edge. The preload stage follows one edge later. In output mode, both capture inputs are ignored.
- R8: The read lock opens on a high-byte read and closes on a low-byte read. While it is open, a capture does not reach the preload stage. The held value moves to the preload stage on the edge after the low-byte read.
- R9: A capture sets the capture flag, and a low-byte read clears it. A capture while the capture flag is already set raises the overcapture flag, and a low-byte read clears that flag as well.
- R10: In output mode, the match output is the registered result of counter equals shadow. In input mode it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 2 | Mode select; 00 is output mode, any other value is input mode |
| preload_en | input | 1 | In output mode, shadow loads only on update events |
| update_evt | input | 1 | Update event pulse from the time base |
| capture_in | input | 1 | Prescaled capture event pulse |
| sw_capture | input | 1 | Software-forced capture pulse |
| counter | input | 16 | Timer counter value |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_lo | input | 1 | Write strobe for the low byte |
| wdata | input | 8 | Write byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| rd_lo | input | 1 | Read strobe for the low byte |
| rdata | output | 8 | Registered read byte |
| shadow_val | output | 16 | Shadow stage value used by the hardware |
| match | output | 1 | Registered counter-equals-shadow result |
| capture_flag | output | 1 | Captured value not yet read |
| overcapture | output | 1 | A capture arrived while an unread value was pending |

## Verification
The assertions assume that each high-byte access is followed by its matching low-byte access before the next pair starts. They also assume that read and write strobes never arrive in the same cycle, and that the capture and update inputs are single-cycle pulses. The directed tasks always issue byte accesses in high-then-low pairs, one strobe per cycle. Inputs change only on the falling edge, and every pulse is held for exactly one clock. Mode changes happen only between scenarios, never inside a locked access pair.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;
  typedef enum logic [1:0] {
    SEL_OUTPUT = 2'b00,
    SEL_IN_A   = 2'b01,
    SEL_IN_B   = 2'b10,
    SEL_IN_C   = 2'b11
  } chan_sel_e;

  function automatic logic is_input(input logic [1:0] sel);
    return sel != SEL_OUTPUT;
  endfunction
endpackage

// File: rtl/cc_access_lock.sv
module cc_access_lock (
  input  logic clk,
  input  logic rst,
  input  logic rd_hi,
  input  logic rd_lo,
  input  logic wr_hi,
  input  logic wr_lo,
  output logic rd_busy,
  output logic wr_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy <= 1'b0;
      wr_busy <= 1'b0;
    end else begin
      if (rd_hi)      rd_busy <= 1'b1;
      else if (rd_lo) rd_busy <= 1'b0;
      if (wr_hi)      wr_busy <= 1'b1;
      else if (wr_lo) wr_busy <= 1'b0;
    end
  end

  assert_rd_lock_open_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_busy && !rd_hi) |=> !rd_busy);
  assert_wr_lock_open_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_busy && !wr_hi) |=> !wr_busy);
endmodule

// File: rtl/cc_preload_reg.sv
module cc_preload_reg #(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int LANES  = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_mode,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              rd_busy,
  input  logic              cap_xfer,
  input  logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] preload,
  output logic [BYTE_W-1:0] rdata
);
  logic [LANES-1:0] lane_we;
  assign lane_we = {wr_hi, wr_lo};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        preload[b*BYTE_W +: BYTE_W] <= '0;
      else if (cap_xfer)
        preload[b*BYTE_W +: BYTE_W] <= shadow[b*BYTE_W +: BYTE_W];
      else if (lane_we[b])
        preload[b*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_hi) rdata <= preload[DATA_W-1:BYTE_W];
    else if (rd_lo) rdata <= preload[BYTE_W-1:0];
  end

  assert_preload_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (in_mode && rd_busy) |=> $stable(preload));
endmodule

// File: rtl/cc_shadow_reg.sv
module cc_shadow_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_mode,
  input  logic              preload_en,
  input  logic              update_evt,
  input  logic              cap_evt,
  input  logic              cap_xfer,
  input  logic              wr_busy,
  input  logic [DATA_W-1:0] counter,
  input  logic [DATA_W-1:0] preload,
  output logic [DATA_W-1:0] shadow,
  output logic              cap_pend,
  output logic              match
);
  logic upd_pend;
  logic cmp_copy;

  assign cmp_copy = !in_mode && !wr_busy &&
                    (!preload_en || update_evt || upd_pend);

  always_ff @(posedge clk) begin
    if (rst)           shadow <= '0;
    else if (cap_evt)  shadow <= counter;
    else if (cmp_copy) shadow <= preload;
  end

  always_ff @(posedge clk) begin
    if (rst || !in_mode) cap_pend <= 1'b0;
    else if (cap_evt)    cap_pend <= 1'b1;
    else if (cap_xfer)   cap_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || in_mode)                        upd_pend <= 1'b0;
    else if (cmp_copy)                         upd_pend <= 1'b0;
    else if (preload_en && update_evt && wr_busy) upd_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) match <= 1'b0;
    else     match <= !in_mode && (counter == shadow);
  end

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_mode && wr_busy) |=> $stable(shadow));
  assert_capture_load_R7: assert property (@(posedge clk) disable iff (rst)
    (in_mode && cap_evt) |=> (shadow == $past(counter)));
  assert_no_pend_output_R7: assert property (@(posedge clk) disable iff (rst)
    !in_mode |=> !cap_pend);
  assert_match_input_R10: assert property (@(posedge clk) disable iff (rst)
    in_mode |=> !match);
endmodule

// File: rtl/cmpcap_reg.sv
module cmpcap_reg
  import cmpcap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        chan_sel,
  input  logic              preload_en,
  input  logic              update_evt,
  input  logic              capture_in,
  input  logic              sw_capture,
  input  logic [DATA_W-1:0] counter,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] rdata,
  output logic [DATA_W-1:0] shadow_val,
  output logic              match,
  output logic              capture_flag,
  output logic              overcapture
);
  logic in_mode, cap_evt, cap_xfer, cap_pend;
  logic rd_busy, wr_busy, wr_hi_q, wr_lo_q;
  logic [DATA_W-1:0] preload;

  assign in_mode  = is_input(chan_sel);
  assign cap_evt  = in_mode && (capture_in || sw_capture);
  assign wr_hi_q  = wr_hi && !in_mode;
  assign wr_lo_q  = wr_lo && !in_mode;
  assign cap_xfer = in_mode && cap_pend && !rd_busy;

  cc_access_lock u_lock (
    .clk(clk), .rst(rst), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .wr_hi(wr_hi_q), .wr_lo(wr_lo_q), .rd_busy(rd_busy), .wr_busy(wr_busy)
  );

  cc_preload_reg #(.BYTE_W(BYTE_W)) u_pre (
    .clk(clk), .rst(rst), .in_mode(in_mode), .wr_hi(wr_hi_q), .wr_lo(wr_lo_q),
    .wdata(wdata), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_busy(rd_busy),
    .cap_xfer(cap_xfer), .shadow(shadow_val), .preload(preload), .rdata(rdata)
  );

  cc_shadow_reg #(.DATA_W(DATA_W)) u_shd (
    .clk(clk), .rst(rst), .in_mode(in_mode), .preload_en(preload_en),
    .update_evt(update_evt), .cap_evt(cap_evt), .cap_xfer(cap_xfer),
    .wr_busy(wr_busy), .counter(counter), .preload(preload),
    .shadow(shadow_val), .cap_pend(cap_pend), .match(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      capture_flag <= 1'b0;
      overcapture  <= 1'b0;
    end else if (cap_evt) begin
      capture_flag <= 1'b1;
      if (capture_flag) overcapture <= 1'b1;
    end else if (rd_lo) begin
      capture_flag <= 1'b0;
      overcapture  <= 1'b0;
    end
  end

  assert_overcapture_set_R9: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && capture_flag) |=> overcapture);
  assert_input_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (in_mode && !cap_xfer) |=> $stable(preload));
endmodule

// File: tb/cmpcap_reg_bench.sv
module cmpcap_reg_bench;
  logic clk = 0, rst = 1;
  logic [1:0] chan_sel = 2'b00;
  logic preload_en = 0, update_evt = 0, capture_in = 0, sw_capture = 0;
  logic [15:0] counter = 16'h0;
  logic wr_hi = 0, wr_lo = 0, rd_hi = 0, rd_lo = 0;
  logic [7:0] wdata = 8'h0;
  logic [7:0] rdata;
  logic [15:0] shadow_val;
  logic match, capture_flag, overcapture;
  int checks = 0, errors = 0;
  logic [15:0] rd16;

  always #10 clk = ~clk;

  cmpcap_reg u_cmpcap_reg (
    .clk(clk), .rst(rst), .chan_sel(chan_sel), .preload_en(preload_en),
    .update_evt(update_evt), .capture_in(capture_in), .sw_capture(sw_capture),
    .counter(counter), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rdata(rdata), .shadow_val(shadow_val),
    .match(match), .capture_flag(capture_flag), .overcapture(overcapture)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [15:0] v);
    @(negedge clk); wr_hi = 1; wdata = v[15:8];
    @(negedge clk); wr_hi = 0; wr_lo = 1; wdata = v[7:0];
    @(negedge clk); wr_lo = 0;
  endtask

  task automatic read16(output logic [15:0] v);
    @(negedge clk); rd_hi = 1;
    @(negedge clk); rd_hi = 0; v[15:8] = rdata; rd_lo = 1;
    @(negedge clk); rd_lo = 0; v[7:0] = rdata;
  endtask

  task automatic pulse_capture(input logic [15:0] c, input logic sw);
    @(negedge clk); counter = c; if (sw) sw_capture = 1; else capture_in = 1;
    @(negedge clk); capture_in = 0; sw_capture = 0;
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 0);
    check("R1 shadow", shadow_val, 0);
    check("R1 match", match, 0);
    check("R1 flags", {capture_flag, overcapture}, 0);
  endtask

  task automatic t_immediate;
    chan_sel = 2'b00; preload_en = 0;
    @(negedge clk); wr_hi = 1; wdata = 8'h12;
    @(negedge clk); wr_hi = 0; check("R5 shadow held mid-write", shadow_val, 16'h0000);
    wr_lo = 1; wdata = 8'h34;
    @(negedge clk); wr_lo = 0; check("R4 shadow one edge later", shadow_val, 16'h0000);
    @(negedge clk); check("R4 immediate copy", shadow_val, 16'h1234);
    read16(rd16); check("R2 byte readback", rd16, 16'h1234);
  endtask

  task automatic t_buffered;
    preload_en = 1;
    wr16(16'hABCD);
    repeat (3) @(negedge clk);
    check("R6 no load without update", shadow_val, 16'h1234);
    update_evt = 1; @(negedge clk); update_evt = 0;
    check("R6 load on update", shadow_val, 16'hABCD);
    wr_hi = 1; wdata = 8'h55;
    @(negedge clk); wr_hi = 0; update_evt = 1;
    @(negedge clk); update_evt = 0;
    check("R6 update held during write", shadow_val, 16'hABCD);
    wr_lo = 1; wdata = 8'hAA;
    @(negedge clk); wr_lo = 0;
    check("R5 lock edge no copy", shadow_val, 16'hABCD);
    @(negedge clk); check("R6 held update applied", shadow_val, 16'h55AA);
    preload_en = 0;
  endtask

  task automatic t_match;
    counter = 16'h55AA; @(negedge clk);
    check("R10 match set", match, 1);
    counter = 16'h55AB; @(negedge clk);
    check("R10 match clear", match, 0);
  endtask

  task automatic t_output_capture_ignored;
    pulse_capture(16'h7777, 1);
    pulse_capture(16'h7777, 0);
    check("R7 capture ignored in output mode", shadow_val, 16'h55AA);
    check("R9 no flag in output mode", capture_flag, 0);
  endtask

  task automatic t_capture;
    chan_sel = 2'b10; @(negedge clk);
    check("R10 match zero in input mode", match, 0);
    @(negedge clk); counter = 16'h5555; capture_in = 1;
    @(negedge clk); capture_in = 0;
    check("R7 shadow captured", shadow_val, 16'h5555);
    read16(rd16); check("R7 preload follows", rd16, 16'h5555);
    pulse_capture(16'h0102, 1);
    read16(rd16); check("R7 software capture", rd16, 16'h0102);
  endtask

  task automatic t_input_write_ignored;
    chan_sel = 2'b01;
    wr16(16'hFFFF);
    read16(rd16); check("R3 write ignored in input mode", rd16, 16'h0102);
  endtask

  task automatic t_read_lock;
    logic [15:0] v;
    @(negedge clk); rd_hi = 1;
    @(negedge clk); rd_hi = 0; v[15:8] = rdata; counter = 16'hBEEF; capture_in = 1;
    @(negedge clk); capture_in = 0; rd_lo = 1;
    @(negedge clk); rd_lo = 0; v[7:0] = rdata;
    check("R8 coherent pair", v, 16'h0102);
    check("R8 shadow has new capture", shadow_val, 16'hBEEF);
    read16(rd16); check("R8 held capture delivered", rd16, 16'hBEEF);
  endtask

  task automatic t_overcapture;
    read16(rd16);
    check("R9 flags cleared by read", {capture_flag, overcapture}, 2'b00);
    pulse_capture(16'h1111, 0);
    check("R9 capture flag", {capture_flag, overcapture}, 2'b10);
    pulse_capture(16'h2222, 0);
    check("R9 overcapture", {capture_flag, overcapture}, 2'b11);
    read16(rd16);
    check("R9 latest value", rd16, 16'h2222);
    check("R9 cleared after read", {capture_flag, overcapture}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    check("R1 after release", shadow_val, 0);
    t_immediate();
    t_buffered();
    t_match();
    t_output_capture_ignored();
    t_capture();
    t_input_write_ignored();
    t_read_lock();
    t_overcapture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule